// File: doc/BRIEF.md
# Dual-Standard Vertical Line Counter

This block tracks the vertical scan position of a raster video controller that can run either a 262-line frame or a 313-line frame. Each pulse on the line-end strobe moves it one scan line forward. It keeps a raw line index that counts straight through the frame. Beside that index it keeps an 8-bit position value for readers. That value is not monotonic: once per frame it steps backward to a point that depends on the selected standard. In the 313-line standard this means the value 0x00 shows up on two different lines of the same frame.

The block also produces a vertical-blank flag and a single-cycle frame-start pulse. Software that waits for line 0 must first see the blank flag fall, and only then look for a position of zero. For that reason the flag falls one line before the real top of the frame. The standard-select input is sampled only when the frame wraps, so a frame is never cut short or stretched part-way through. Every output comes straight from a flop and changes only on a clock edge.

Top module: `vline_counter`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `line_idx`, `vpos` and `frame_start` are 0 and `vblank` is 0. The standard is loaded from `pal_sel` during reset.
- R2: All outputs hold their values on any clock edge where `line_end` is low. On an edge where `line_end` is high, `line_idx` advances by one line.
- R3: With the 262-line standard latched (`pal_sel` = 0), `line_idx` runs from 0 to 261 and then returns to 0. With the 313-line standard latched (`pal_sel` = 1), it runs from 0 to 312 and then returns to 0.
- R4: In the 262-line standard, `vpos` equals `line_idx` for lines 0 through 234 (positions 0x00 to 0xEA). On line 235 it shows 0xE5. From there it rises by one per line up to 0xFF on line 261.
- R5: In the 313-line standard, `vpos` runs 0x00 to 0xFF over lines 0 to 255. It then shows 0x00, 0x01 and 0x02 on lines 256 to 258, and 0xCA on line 259. From there it rises by one per line up to 0xFF on line 312.
- R6: `vblank` is 0 on lines 0 to 223 and is 1 from line 224 onward. Line 224 is the line whose position is 224.
- R7: `vblank` stays 1 up to and including the line with position 0xFE. It is 0 on the final line of the frame (position 0xFF), and stays 0 through line 0 of the next frame.
- R8: `frame_start` is high for exactly the one cycle that follows the edge on which `line_idx` returns from the last line to 0. It is low at all other times.
- R9: A change on `pal_sel` has no effect on frame length or position sequence until the next wrap. The value of `pal_sel` on the wrapping edge sets the standard for the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_end | input | 1 | One-cycle strobe at the end of each scan line |
| pal_sel | input | 1 | Standard select: 0 = 262 lines, 1 = 313 lines |
| vpos | output | 8 | Visible vertical position, with one backward jump per frame |
| vblank | output | 1 | Vertical-blank status flag |
| frame_start | output | 1 | One-cycle pulse when the raw index wraps to 0 |
| line_idx | output | 9 | Raw line index within the frame |

## Verification
The frame wrap and a standard switch can land on the same clock edge. On that edge the index returns to zero, the frame-start pulse fires and the new standard is latched, all together. The bench provokes this case in every second frame: it drives the opposite standard on `pal_sel` during the strobe of the last line. It then judges the result by checking the length of the following frame and where its position jump falls, both against a model of that new standard. Random mid-frame toggles of `pal_sel` check the opposite case, where nothing may change until the wrap.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  typedef enum logic {
    STD_SHORT = 1'b0,
    STD_LONG  = 1'b1
  } vstd_e;

  // Raw index at which the position jumps backward, derived from the
  // frame length and the landing value so the tail reaches all-ones exactly
  // on the last line.
  function automatic int unsigned jump_line(input int unsigned lines,
                                            input int unsigned land,
                                            input int unsigned vis_w);
    return lines - ((32'd1 << vis_w) - land);
  endfunction

endpackage

// File: rtl/vlc_std_latch.sv
module vlc_std_latch
  import vlc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pal_sel,
  input  logic  wrap,
  output vstd_e std_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      std_q <= vstd_e'(pal_sel);
    else if (wrap)
      std_q <= vstd_e'(pal_sel);
  end

endmodule

// File: rtl/vlc_line_index.sv
module vlc_line_index
  import vlc_pkg::*;
#(
  parameter int unsigned SHORT_LINES = 262,
  parameter int unsigned LONG_LINES  = 313,
  parameter int unsigned IDX_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  vstd_e            std_q,
  output logic [IDX_W-1:0] idx,
  output logic             wrap,
  output logic             frame_start
);

  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_LINES - 1);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_LINES - 1);

  logic [IDX_W-1:0] last;
  assign last = (std_q == STD_LONG) ? LONG_LAST : SHORT_LAST;
  assign wrap = line_end && (idx == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx         <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= wrap;
      if (wrap)
        idx <= '0;
      else if (line_end)
        idx <= idx + 1'b1;
    end
  end

  a_r3_idx_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= last);

  a_r2_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(idx));

  a_r8_start_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (idx == '0));

endmodule

// File: rtl/vlc_visible_count.sv
module vlc_visible_count
  import vlc_pkg::*;
#(
  parameter int unsigned SHORT_LINES = 262,
  parameter int unsigned LONG_LINES  = 313,
  parameter int unsigned SHORT_LAND  = 8'hE5,
  parameter int unsigned LONG_LAND   = 8'hCA,
  parameter int unsigned IDX_W       = 9,
  parameter int unsigned VIS_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  logic             wrap,
  input  vstd_e            std_q,
  input  logic [IDX_W-1:0] idx,
  output logic [VIS_W-1:0] vpos
);

  localparam int unsigned SHORT_JMP = jump_line(SHORT_LINES, SHORT_LAND, VIS_W);
  localparam int unsigned LONG_JMP  = jump_line(LONG_LINES, LONG_LAND, VIS_W);

  logic [IDX_W-1:0] jmp_at;
  logic [VIS_W-1:0] land;
  assign jmp_at = (std_q == STD_LONG) ? IDX_W'(LONG_JMP) : IDX_W'(SHORT_JMP);
  assign land   = (std_q == STD_LONG) ? VIS_W'(LONG_LAND) : VIS_W'(SHORT_LAND);

  always_ff @(posedge clk) begin
    if (!rst_n)
      vpos <= '0;
    else if (wrap)
      vpos <= '0;
    else if (line_end && (idx + 1'b1 == jmp_at))
      vpos <= land;
    else if (line_end)
      vpos <= vpos + 1'b1;
  end

  // R4 / R5: position before the jump tracks the low bits of the raw index
  a_r4_head_follows_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (idx < jmp_at) |-> (vpos == idx[VIS_W-1:0]));

  // R4 / R5: position after the jump is offset from the landing value
  a_r5_tail_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (idx >= jmp_at) |-> (vpos == VIS_W'(idx - jmp_at) + land));

  a_r2_vpos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vpos));

endmodule

// File: rtl/vlc_blank_flag.sv
module vlc_blank_flag
  import vlc_pkg::*;
#(
  parameter int unsigned SHORT_LINES  = 262,
  parameter int unsigned LONG_LINES   = 313,
  parameter int unsigned ACTIVE_LINES = 224,
  parameter int unsigned IDX_W        = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  vstd_e            std_q,
  input  logic [IDX_W-1:0] idx,
  output logic             vblank
);

  localparam logic [IDX_W-1:0] SET_BEFORE = IDX_W'(ACTIVE_LINES - 1);
  localparam logic [IDX_W-1:0] SHORT_CLR  = IDX_W'(SHORT_LINES - 2);
  localparam logic [IDX_W-1:0] LONG_CLR   = IDX_W'(LONG_LINES - 2);

  logic [IDX_W-1:0] clr_before;
  assign clr_before = (std_q == STD_LONG) ? LONG_CLR : SHORT_CLR;

  always_ff @(posedge clk) begin
    if (!rst_n)
      vblank <= 1'b0;
    else if (line_end && idx == SET_BEFORE)
      vblank <= 1'b1;
    else if (line_end && idx == clr_before)
      vblank <= 1'b0;
  end

  a_r6_clear_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> (idx >= IDX_W'(ACTIVE_LINES)));

  a_r7_only_last_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!vblank && idx >= IDX_W'(ACTIVE_LINES)) |-> (idx == clr_before + 1'b1));

endmodule

// File: rtl/vline_counter.sv
module vline_counter
  import vlc_pkg::*;
#(
  parameter int unsigned SHORT_LINES  = 262,
  parameter int unsigned LONG_LINES   = 313,
  parameter int unsigned SHORT_LAND   = 8'hE5,
  parameter int unsigned LONG_LAND    = 8'hCA,
  parameter int unsigned ACTIVE_LINES = 224,
  parameter int unsigned VIS_W        = 8,
  parameter int unsigned IDX_W        = $clog2((LONG_LINES > SHORT_LINES) ? LONG_LINES : SHORT_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  logic             pal_sel,
  output logic [VIS_W-1:0] vpos,
  output logic             vblank,
  output logic             frame_start,
  output logic [IDX_W-1:0] line_idx
);

  vstd_e std_q;
  logic  wrap;

  vlc_std_latch u_std (
    .clk     (clk),
    .rst_n   (rst_n),
    .pal_sel (pal_sel),
    .wrap    (wrap),
    .std_q   (std_q)
  );

  vlc_line_index #(
    .SHORT_LINES (SHORT_LINES),
    .LONG_LINES  (LONG_LINES),
    .IDX_W       (IDX_W)
  ) u_idx (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_end    (line_end),
    .std_q       (std_q),
    .idx         (line_idx),
    .wrap        (wrap),
    .frame_start (frame_start)
  );

  vlc_visible_count #(
    .SHORT_LINES (SHORT_LINES),
    .LONG_LINES  (LONG_LINES),
    .SHORT_LAND  (SHORT_LAND),
    .LONG_LAND   (LONG_LAND),
    .IDX_W       (IDX_W),
    .VIS_W       (VIS_W)
  ) u_vis (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_end (line_end),
    .wrap     (wrap),
    .std_q    (std_q),
    .idx      (line_idx),
    .vpos     (vpos)
  );

  vlc_blank_flag #(
    .SHORT_LINES  (SHORT_LINES),
    .LONG_LINES   (LONG_LINES),
    .ACTIVE_LINES (ACTIVE_LINES),
    .IDX_W        (IDX_W)
  ) u_vb (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_end (line_end),
    .std_q    (std_q),
    .idx      (line_idx),
    .vblank   (vblank)
  );

  a_r9_std_moves_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (std_q != $past(std_q)) |-> frame_start);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r7_top_is_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !vblank);

endmodule

// File: tb/tb_vline_counter.sv
module tb_vline_counter;

  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_end = 1'b0;
  logic       pal_sel = 1'b0;
  logic [7:0] vpos;
  logic       vblank;
  logic       frame_start;
  logic [8:0] line_idx;

  int n_checks = 0;
  int n_fail   = 0;

  int  m_raw = 0;
  bit  m_std = 1'b0;
  bit  m_fs  = 1'b0;
  int  frames = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vline_counter dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_end    (line_end),
    .pal_sel     (pal_sel),
    .vpos        (vpos),
    .vblank      (vblank),
    .frame_start (frame_start),
    .line_idx    (line_idx)
  );

  function automatic int frame_len(bit p);
    return p ? 313 : 262;
  endfunction

  function automatic int exp_pos(int r, bit p);
    if (!p) return (r <= 234) ? r : (r - 235 + 229);
    if (r <= 255) return r;
    if (r <= 258) return r - 256;
    return r - 259 + 202;
  endfunction

  function automatic int exp_vb(int r, bit p);
    return (r >= 224 && r <= frame_len(p) - 2) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (raw %0d std %0d)", tag, act, exp, m_raw, m_std);
    end
  endtask

  task automatic check_all();
    chk("R3 line_idx", int'(line_idx), m_raw);
    chk(m_std ? "R5 vpos" : "R4 vpos", int'(vpos), exp_pos(m_raw, m_std));
    chk((m_raw >= 224) ? "R7 vblank" : "R6 vblank", int'(vblank), exp_vb(m_raw, m_std));
    chk("R8 frame_start", int'(frame_start), int'(m_fs));
  endtask

  task automatic step(bit le, bit ps);
    @(negedge clk);
    line_end = le;
    pal_sel  = ps;
    @(posedge clk);
    m_fs = 1'b0;
    if (le) begin
      if (m_raw == frame_len(m_std) - 1) begin
        m_raw = 0;
        m_std = ps;
        m_fs  = 1'b1;
        frames++;
      end else begin
        m_raw++;
      end
    end
    @(negedge clk);
    line_end = 1'b0;
    check_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    bit ps;
    bit le;
    seed = 32'h5eed_1234;
    void'($urandom(seed));

    // R1: reset state
    rst_n   = 1'b0;
    pal_sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 line_idx", int'(line_idx), 0);
    chk("R1 vpos", int'(vpos), 0);
    chk("R1 vblank", int'(vblank), 0);
    chk("R1 frame_start", int'(frame_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    m_raw = 0; m_std = 1'b0; m_fs = 1'b0;
    chk("R1 after release", int'(line_idx) + int'(vpos), 0);

    // R2: idle cycles change nothing
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1);
      chk("R2 hold idx", int'(line_idx), 2);
    end

    // R9 directed: mid-frame toggle ignored for the current frame
    ps = 1'b1;
    for (int i = 0; i < 300; i++) begin
      step(1'b1, ps);
      ps = ~ps;
      if (frames > 0) break;
    end

    // random gaps and toggles; every other wrap switches standard
    ps = m_std;
    for (int i = 0; i < STEPS; i++) begin
      le = ($urandom % 4) != 0;
      if ($urandom % 97 == 0) ps = ~ps;
      if (le && m_raw == frame_len(m_std) - 1 && frames[0] == 1'b0)
        ps = ~m_std;
      step(le, ps);
    end

    // R3 / R9: reset with long standard selected, full frame check
    @(negedge clk);
    rst_n = 1'b0; pal_sel = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_raw = 0; m_std = 1'b1; m_fs = 1'b0;
    for (int i = 0; i < 313; i++) step(1'b1, 1'b1);
    chk("R3 long frame wrap", int'(line_idx), 0);
    chk("R8 pulse at wrap", int'(frame_start), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule